// File: doc/BRIEF.md
# Decode-Stage Static Branch Guesser with Return Stack

This block makes a second-chance branch prediction in the decode stage. That stage comes after two fetch stages. The block is meant for cases where the fetch-stage target cache had nothing to say. Decode supplies a valid flag, a two-bit branch kind, the instruction address and a signed displacement. The block then answers in the same cycle with a predicted-taken flag, a predicted target and a redirect request to the fetch unit.

The direction of a conditional direct branch comes from the sign of its displacement. Backward branches are guessed taken, because they usually close loops. Forward branches are guessed not taken. A procedure call saves its return address on a small circular stack. An unconditional return takes its target from the top of that stack. A conditional return is never guessed. A flush input empties the stack, so that calls fetched down a wrong path leave no trace.

A hit flag from the fetch-stage predictor removes the redirect. The stack is still updated in that case, so that it keeps tracking the real call nesting.

Top module: `static_branch_guess`

## Requirements
- R1: A valid conditional direct branch (kind 2'b00) with a non-negative displacement (sign bit 0) gives pred_taken=0, no redirect, and pred_target = pc + 4.
- R2: A valid conditional direct branch with a negative displacement (sign bit 1) gives pred_taken=1 and pred_target = pc + sign-extended displacement. It raises redirect unless dyn_hit is set.
- R3: A valid call (kind 2'b01) is guessed taken with pred_target = pc + sign-extended displacement. In the same cycle it pushes pc + 4 onto the return stack.
- R4: A valid unconditional return (kind 2'b10) on a non-empty stack is guessed taken. Its target is the most recently pushed address still held, and it pops that entry, so returns come back in reverse call order.
- R5: An unconditional return on an empty stack gives pred_taken=0 and pred_target = pc + 4, and the stack stays empty.
- R6: The stack holds 3 entries. A push when it is full overwrites the oldest entry, and occupancy stays at 3.
- R7: A conditional return (kind 2'b11) gives pred_taken=0 and pred_target = pc + 4, and it leaves the stack contents and occupancy unchanged.
- R8: When dyn_hit is 1, redirect is 0. Pushes and pops still take place as if dyn_hit were 0.
- R9: When flush is 1 at a clock edge, the stack is left empty. Flush wins over a push or pop in the same cycle.
- R10: When dec_valid is 0, pred_taken and redirect are 0, and the stack does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dec_valid | input | 1 | A decoded branch is present this cycle |
| dec_kind | input | 2 | 00 cond direct, 01 call, 10 return, 11 conditional return |
| dec_pc | input | AW (32) | Address of the branch instruction |
| dec_disp | input | DW (24) | Signed byte displacement of a direct branch or call |
| dyn_hit | input | 1 | The fetch-stage predictor already handled this branch |
| flush | input | 1 | Empty the return stack at this edge |
| pred_taken | output | 1 | Static guess is taken |
| pred_target | output | AW (32) | Guessed next address |
| redirect | output | 1 | Request fetch to restart at pred_target |

## Verification
The checker tests the following on every cycle: the direction rules for forward and backward conditionals, the absence of any guess for a return on an empty stack, a conditional return never popping, the redirect being suppressed by a dyn_hit or an idle cycle, the occupancy bound, its growth on a push, and the empty stack after a flush. Some behaviours depend on stored data and ordering, and only the bench scenarios show them. These are the return addresses coming back in reverse call order, the oldest entry being lost after a fourth nested call, a conditional return leaving the stack intact for a later return, a stack update made under a dyn_hit, and a flush that coincides with a call.

// File: rtl/sbg_pkg.sv
package sbg_pkg;
  typedef enum logic [1:0] {
    K_COND = 2'b00,
    K_CALL = 2'b01,
    K_RET  = 2'b10,
    K_CRET = 2'b11
  } br_kind_t;

  localparam int unsigned INSN_BYTES = 4;
endpackage

// File: rtl/sbg_ret_stack.sv
module sbg_ret_stack #(
  parameter int AW    = 32,
  parameter int DEPTH = 3,
  localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int OW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic          push,
  input  logic          pop,
  input  logic [AW-1:0] push_addr,
  output logic [AW-1:0] top_addr,
  output logic [OW-1:0] occ
);
  logic [AW-1:0] slot [DEPTH];
  logic [PW-1:0] wr_ptr;

  function automatic logic [PW-1:0] ptr_inc(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  function automatic logic [PW-1:0] ptr_dec(input logic [PW-1:0] p);
    return (p == '0) ? PW'(DEPTH - 1) : p - 1'b1;
  endfunction

  assign top_addr = slot[ptr_dec(wr_ptr)];

  always_ff @(posedge clk) begin
    if (!rst_n || flush) begin
      wr_ptr <= '0;
      occ    <= '0;
    end else if (push) begin
      wr_ptr <= ptr_inc(wr_ptr);
      if (occ != OW'(DEPTH)) occ <= occ + 1'b1;
    end else if (pop && occ != '0) begin
      wr_ptr <= ptr_dec(wr_ptr);
      occ    <= occ - 1'b1;
    end
  end

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    always_ff @(posedge clk) begin
      if (!rst_n) slot[i] <= '0;
      else if (push && !flush && wr_ptr == PW'(i)) slot[i] <= push_addr;
    end
  end
endmodule

// File: rtl/sbg_dir.sv
module sbg_dir #(
  parameter int AW = 32,
  parameter int DW = 24
) (
  input  sbg_pkg::br_kind_t kind,
  input  logic [AW-1:0]     pc,
  input  logic [DW-1:0]     disp,
  input  logic              stack_nonempty,
  input  logic [AW-1:0]     stack_top,
  output logic              guess_taken,
  output logic [AW-1:0]     guess_target,
  output logic [AW-1:0]     seq_addr
);
  import sbg_pkg::*;

  function automatic logic [AW-1:0] rel_target(input logic [AW-1:0] p, input logic [DW-1:0] d);
    return p + {{(AW-DW){d[DW-1]}}, d};
  endfunction

  assign seq_addr = pc + AW'(INSN_BYTES);

  always_comb begin
    guess_taken  = 1'b0;
    guess_target = seq_addr;
    unique case (kind)
      K_COND: if (disp[DW-1]) begin
        guess_taken  = 1'b1;
        guess_target = rel_target(pc, disp);
      end
      K_CALL: begin
        guess_taken  = 1'b1;
        guess_target = rel_target(pc, disp);
      end
      K_RET: if (stack_nonempty) begin
        guess_taken  = 1'b1;
        guess_target = stack_top;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/static_branch_guess.sv
module static_branch_guess #(
  parameter int AW    = 32,
  parameter int DW    = 24,
  parameter int DEPTH = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          dec_valid,
  input  logic [1:0]    dec_kind,
  input  logic [AW-1:0] dec_pc,
  input  logic [DW-1:0] dec_disp,
  input  logic          dyn_hit,
  input  logic          flush,
  output logic          pred_taken,
  output logic [AW-1:0] pred_target,
  output logic          redirect
);
  import sbg_pkg::*;
  localparam int OW = $clog2(DEPTH + 1);

  br_kind_t      kind;
  logic [OW-1:0] occ;
  logic [AW-1:0] top_addr, seq_addr;
  logic          guess_taken, push_ev, pop_ev, nonempty;

  assign kind     = br_kind_t'(dec_kind);
  assign nonempty = (occ != '0);
  assign push_ev  = dec_valid && kind == K_CALL;
  assign pop_ev   = dec_valid && kind == K_RET && nonempty;

  sbg_dir #(.AW(AW), .DW(DW)) u_dir (
    .kind(kind), .pc(dec_pc), .disp(dec_disp),
    .stack_nonempty(nonempty), .stack_top(top_addr),
    .guess_taken(guess_taken), .guess_target(pred_target), .seq_addr(seq_addr)
  );

  sbg_ret_stack #(.AW(AW), .DEPTH(DEPTH)) u_stack (
    .clk(clk), .rst_n(rst_n), .flush(flush),
    .push(push_ev), .pop(pop_ev), .push_addr(seq_addr),
    .top_addr(top_addr), .occ(occ)
  );

  assign pred_taken = dec_valid && guess_taken;
  assign redirect   = pred_taken && !dyn_hit;
endmodule

// File: rtl/sbg_checker.sv
module sbg_checker #(
  parameter int DW    = 24,
  parameter int DEPTH = 3,
  localparam int OW   = $clog2(DEPTH + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          dec_valid,
  input logic [1:0]    dec_kind,
  input logic [DW-1:0] dec_disp,
  input logic          dyn_hit,
  input logic          flush,
  input logic          pred_taken,
  input logic          redirect,
  input logic [OW-1:0] occ,
  input logic          push_ev,
  input logic          pop_ev
);
  assert_fwd_not_taken_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_valid && dec_kind == 2'b00 && !dec_disp[DW-1]) |-> (!pred_taken && !redirect));
  assert_bwd_taken_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_valid && dec_kind == 2'b00 && dec_disp[DW-1]) |-> pred_taken);
  assert_empty_ret_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_valid && dec_kind == 2'b10 && occ == '0) |-> (!pred_taken && !pop_ev));
  assert_occ_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
    occ <= OW'(DEPTH));
  assert_push_grows_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (push_ev && !flush && occ < OW'(DEPTH)) |=> occ == $past(occ) + 1'b1);
  assert_cret_no_pop_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_valid && dec_kind == 2'b11) |-> (!pop_ev && !pred_taken));
  assert_hit_no_redirect_R8: assert property (@(posedge clk) disable iff (!rst_n)
    dyn_hit |-> !redirect);
  assert_flush_empty_R9: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> occ == '0);
  assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !dec_valid |-> (!pred_taken && !redirect && !push_ev && !pop_ev));
endmodule

bind static_branch_guess sbg_checker #(.DW(DW), .DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .dec_valid(dec_valid), .dec_kind(dec_kind),
  .dec_disp(dec_disp), .dyn_hit(dyn_hit), .flush(flush),
  .pred_taken(pred_taken), .redirect(redirect), .occ(occ),
  .push_ev(push_ev), .pop_ev(pop_ev)
);

// File: tb/static_branch_guess_tb.sv
module static_branch_guess_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        dec_valid = 1'b0;
  logic [1:0]  dec_kind = 2'b00;
  logic [31:0] dec_pc = '0;
  logic [23:0] dec_disp = '0;
  logic        dyn_hit = 1'b0;
  logic        flush = 1'b0;
  logic        pred_taken, redirect;
  logic [31:0] pred_target;

  int n_vec = 0;
  int n_bad = 0;
  logic        s_tk, s_rd;
  logic [31:0] s_tg;

  static_branch_guess u_dut (
    .clk(clk), .rst_n(rst_n), .dec_valid(dec_valid), .dec_kind(dec_kind),
    .dec_pc(dec_pc), .dec_disp(dec_disp), .dyn_hit(dyn_hit), .flush(flush),
    .pred_taken(pred_taken), .pred_target(pred_target), .redirect(redirect)
  );

  always #5 clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // drive one branch for one cycle; outputs sampled mid-cycle
  task automatic step(input logic [1:0] k, input logic [31:0] pc, input logic [23:0] d,
                      input logic hit, input logic fl = 1'b0, input logic v = 1'b1);
    @(negedge clk);
    dec_valid = v; dec_kind = k; dec_pc = pc; dec_disp = d; dyn_hit = hit; flush = fl;
    #2;
    s_tk = pred_taken; s_tg = pred_target; s_rd = redirect;
    @(posedge clk);
    #1;
    dec_valid = 1'b0; dyn_hit = 1'b0; flush = 1'b0;
  endtask

  task automatic expect_pred(input string req, input logic tk, input logic [31:0] tg, input logic rd);
    chk(req, {31'b0, s_tk}, {31'b0, tk});
    chk(req, s_tg, tg);
    chk(req, {31'b0, s_rd}, {31'b0, rd});
  endtask

  task automatic t_reset;
    #2;
    chk("R10 reset taken", {31'b0, pred_taken}, 32'd0);
    chk("R10 reset redirect", {31'b0, redirect}, 32'd0);
  endtask

  task automatic t_cond;
    step(2'b00, 32'h1000, 24'h000010, 1'b0); expect_pred("R1", 1'b0, 32'h1004, 1'b0);
    step(2'b00, 32'h1000, 24'h000000, 1'b0); expect_pred("R1 zero", 1'b0, 32'h1004, 1'b0);
    step(2'b00, 32'h2000, 24'hFFFFF8, 1'b0); expect_pred("R2", 1'b1, 32'h1FF8, 1'b1);
    step(2'b00, 32'h2000, 24'hFFFFF8, 1'b1); expect_pred("R8 cond hit", 1'b1, 32'h1FF8, 1'b0);
  endtask

  task automatic t_call_ret;
    step(2'b01, 32'h100, 24'h000040, 1'b0); expect_pred("R3", 1'b1, 32'h140, 1'b1);
    step(2'b10, 32'h500, 24'h0, 1'b0);      expect_pred("R4", 1'b1, 32'h104, 1'b1);
    step(2'b10, 32'h500, 24'h0, 1'b0);      expect_pred("R5", 1'b0, 32'h504, 1'b0);
  endtask

  task automatic t_overflow;
    step(2'b01, 32'h10, 24'h8, 1'b0);
    step(2'b01, 32'h20, 24'h8, 1'b0);
    step(2'b01, 32'h30, 24'h8, 1'b0);
    step(2'b01, 32'h40, 24'h8, 1'b0);
    step(2'b10, 32'h900, 24'h0, 1'b0); expect_pred("R4 R6 first", 1'b1, 32'h44, 1'b1);
    step(2'b10, 32'h900, 24'h0, 1'b0); expect_pred("R6 second", 1'b1, 32'h34, 1'b1);
    step(2'b10, 32'h900, 24'h0, 1'b0); expect_pred("R6 third", 1'b1, 32'h24, 1'b1);
    step(2'b10, 32'h900, 24'h0, 1'b0); expect_pred("R6 oldest lost", 1'b0, 32'h904, 1'b0);
  endtask

  task automatic t_cret;
    step(2'b01, 32'h600, 24'h20, 1'b0);
    step(2'b11, 32'h700, 24'h0, 1'b0); expect_pred("R7", 1'b0, 32'h704, 1'b0);
    step(2'b10, 32'h800, 24'h0, 1'b0); expect_pred("R7 kept", 1'b1, 32'h604, 1'b1);
  endtask

  task automatic t_hit_stack;
    step(2'b01, 32'hA00, 24'h8, 1'b1); expect_pred("R8 call hit", 1'b1, 32'hA08, 1'b0);
    step(2'b10, 32'hC00, 24'h0, 1'b1); expect_pred("R8 ret hit", 1'b1, 32'hA04, 1'b0);
    step(2'b10, 32'hC00, 24'h0, 1'b0); expect_pred("R8 popped", 1'b0, 32'hC04, 1'b0);
  endtask

  task automatic t_flush;
    step(2'b01, 32'hD00, 24'h8, 1'b0);
    step(2'b00, 32'h0, 24'h0, 1'b0, 1'b1, 1'b0);
    step(2'b10, 32'hE00, 24'h0, 1'b0); expect_pred("R9", 1'b0, 32'hE04, 1'b0);
    step(2'b01, 32'hF00, 24'h8, 1'b0, 1'b1);
    step(2'b10, 32'hE00, 24'h0, 1'b0); expect_pred("R9 same cycle", 1'b0, 32'hE04, 1'b0);
  endtask

  task automatic t_idle;
    step(2'b01, 32'h300, 24'h8, 1'b0);
    step(2'b10, 32'h400, 24'h0, 1'b0, 1'b0, 1'b0); expect_pred("R10 idle ret", 1'b0, 32'h304, 1'b0);
    step(2'b01, 32'h350, 24'h8, 1'b0, 1'b0, 1'b0); expect_pred("R10 idle call", 1'b0, 32'h358, 1'b0);
    step(2'b10, 32'h400, 24'h0, 1'b0); expect_pred("R10 intact", 1'b1, 32'h304, 1'b1);
    step(2'b10, 32'h400, 24'h0, 1'b0); expect_pred("R10 no push", 1'b0, 32'h404, 1'b0);
  endtask

  initial begin
    #200000;
    n_bad++;
    $display("FAIL watchdog actual=running expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    t_reset();
    t_cond();
    t_call_ret();
    t_overflow();
    t_cret();
    t_hit_stack();
    t_flush();
    t_idle();
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule